// File: doc/BRIEF.md
# Miss Tracking Fill-Entry Pool

This block keeps track of first-level data cache misses that are still in flight. It has a small pool of entries. Each entry records the missing line's address, the kind of request that opened it, and whether it is waiting for a line fill or holding write-combined streaming data. Two request ports feed the pool, and each can present one miss per cycle. The cache lookup has already been done upstream, so every valid request is a miss. When an entry is opened for a normal miss, the block issues a line request to the next level on the following cycle. That request carries the entry index. The next level returns that index with the fill, and the fill releases the entry.

Demand loads (cacheable and uncacheable), stores and software prefetches of all three hint levels compete for the same entries. When the pool is exhausted, the request is refused on `req_ready` and must be held by the requester until space appears. A saturating event counter records every refusal, and it can advance by two in one cycle. A miss to a line that is already waiting merges into that entry. A streaming store opens an entry in write-combining state and is released once the next-level queue accepts it. A hardware first-level prefetch is quietly suppressed whenever the pool is busier than a programmable limit.

Top module: `fill_track_pool`

## Requirements
- R1: After reset:
  - all entries are free;
  - `busy_count` and `full_events` are 0;
  - no line request is issued and no drain is offered.
- R2: A request that opens an entry takes the lowest free index. An entry opened by any kind other than 7 raises `nl_req_valid` on the cycle after acceptance, together with that index, the stored line and the stored kind.
  - The line is byte address bits [39:6], supplied directly on `req_line`.
  - Kind codes:
    - 0: cacheable load
    - 1: uncacheable load
    - 2: store
    - 3, 4, 5: software prefetch to first, second or outer level
    - 6: hardware prefetch
    - 7: streaming store
- R3: A waiting entry stays busy until `fill_valid` returns its index. A fill naming a free entry, a write-combining entry or an index of 10 or more has no effect. `busy_count` counts entries that are not free.
- R4: Software prefetches (kinds 3, 4, 5) take entries exactly like demand misses. A prefetch that meets a full pool is stalled, never dropped, and is accepted once an entry frees.
- R5: `req_ready[p]` is low only when port p needs a new entry and none is available. The requester then holds the request, and it is retried each cycle. An entry freed by a fill or drain becomes reusable on the following cycle.
- R6: `full_events` increases by the number of ports refused in the cycle, 0 to 2, and saturates at all ones.
- R7: When both ports open entries in the same cycle, port 0 receives the lower free index.
- R8: Merging of a request that is not a streaming store:
  - A request of kind other than 1 and 7 whose line matches a waiting entry is accepted without a new entry and without a line request.
  - Port 1 also merges into an entry that port 0 opens for the same line in the same cycle.
  - Kind 1 never merges.
- R9: Streaming stores:
  - A kind 7 request opens an entry in write-combining state and issues no line request.
  - The lowest-index write-combining entry is offered on `wc_drain_*` and is freed when `wc_drain_ready` is high.
  - A further kind 7 to the same line merges into that entry, unless the entry is being drained in that cycle.
- R10: A kind 6 request that does not merge is accepted but suppressed, with no entry taken and no refusal counted, when occupancy exceeds `cfg_hwpf_limit` or no entry is free. For port 1, occupancy includes port 0's allocation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 2 | Miss request valid, one bit per port |
| req_kind | input | 2x3 | Request kind code per port |
| req_line | input | 2x34 | Line address per port |
| req_ready | output | 2 | Request accepted this cycle (low = stalled) |
| nl_req_valid | output | 2 | Line request to next level, per port slot |
| nl_req_idx | output | 2x4 | Entry index of each line request |
| nl_req_line | output | 2x34 | Line address of each line request |
| nl_req_kind | output | 2x3 | Kind stored in the requesting entry |
| fill_valid | input | 1 | Line fill returned |
| fill_idx | input | 4 | Entry index of the returned fill |
| wc_drain_valid | output | 1 | A write-combining entry is offered for hand-off |
| wc_drain_idx | output | 4 | Index of the offered entry |
| wc_drain_line | output | 34 | Line of the offered entry |
| wc_drain_ready | input | 1 | Next-level queue takes the offered entry |
| cfg_hwpf_limit | input | 4 | Occupancy limit for hardware prefetch |
| busy_count | output | 4 | Number of occupied entries |
| full_events | output | 16 | Saturating count of refused requests |

## Verification
The main function is exercised with several kinds of traffic, and each separates different faults:
- **Single-port misses to distinct lines** confirm lowest-index allocation and the line request.
- **Paired misses** separate port-priority faults from plain allocation.
- **Repeated misses to a waiting line** tell merging apart from double allocation. The uncacheable variant shows that merging is correctly withheld.
- **Holding both ports against a full pool** separates stalling from dropping, one-per-cycle counting from two-per-cycle counting, and saturation from wrap-around.
- **Random traffic over a few lines** covers the interactions between fills, drains and allocations in the same cycle. It uses random fills, including stray indices, and random drain acceptance, and mixes all eight kinds.

// File: rtl/fill_pool_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the fill-entry pool.
// Assumes request kinds arrive as 3-bit codes and entry states fit 2 bits.
package fill_pool_pkg;

    typedef enum logic [2:0] {
        RK_LOAD     = 3'd0,
        RK_LOAD_UC  = 3'd1,
        RK_STORE    = 3'd2,
        RK_SWPF_L1  = 3'd3,
        RK_SWPF_L2  = 3'd4,
        RK_SWPF_NTA = 3'd5,
        RK_HWPF     = 3'd6,
        RK_NTSTORE  = 3'd7
    } req_kind_e;

    typedef enum logic [1:0] {
        ES_FREE = 2'd0,
        ES_WAIT = 2'd1,
        ES_WC   = 2'd2
    } entry_state_e;

    // True when a request of this kind may attach to an existing entry.
    function automatic logic kind_can_merge(input logic [2:0] k);
        return k != RK_LOAD_UC;
    endfunction

    // True for streaming stores, which use write-combining entries.
    function automatic logic kind_is_stream(input logic [2:0] k);
        return k == RK_NTSTORE;
    endfunction

endpackage

// File: rtl/fill_free_pick.sv
`timescale 1ns/1ps
// Lowest and second-lowest set-bit finder over the free vector.
// Assumes at most two allocations per cycle; purely combinational.
module fill_free_pick #(
    parameter int N     = 10,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     free_vec,
    output logic             first_ok,
    output logic [IDX_W-1:0] first_idx,
    output logic             second_ok,
    output logic [IDX_W-1:0] second_idx
);

    // Scan upward, recording the first two free positions.
    always_comb begin
        first_ok   = 1'b0;
        first_idx  = '0;
        second_ok  = 1'b0;
        second_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (free_vec[i]) begin
                if (!first_ok) begin
                    first_ok  = 1'b1;
                    first_idx = IDX_W'(i);
                end else if (!second_ok) begin
                    second_ok  = 1'b1;
                    second_idx = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/fill_line_match.sv
`timescale 1ns/1ps
// Associative compare of one request line against all entries in a wanted
// state, with one entry optionally masked out. Returns the lowest hit.
module fill_line_match #(
    parameter int N      = 10,
    parameter int LINE_W = 34,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic [N-1:0][1:0]        state_vec,
    input  logic [N-1:0][LINE_W-1:0] line_vec,
    input  logic [LINE_W-1:0]        line,
    input  logic [1:0]               want_state,
    input  logic                     mask_en,
    input  logic [IDX_W-1:0]         mask_idx,
    output logic                     hit,
    output logic [IDX_W-1:0]         hit_idx
);

    logic [N-1:0] hit_vec;

    // One comparator per entry.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = (state_vec[i] == want_state) &&
                            (line_vec[i] == line) &&
                            !(mask_en && (mask_idx == IDX_W'(i)));
    end

    // Priority-encode the lowest matching entry.
    always_comb begin
        hit     = |hit_vec;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/fill_entry_bank.sv
`timescale 1ns/1ps
// Storage for the pool entries: state, line and kind per entry.
// Assumes allocations only target free entries, and the two allocation
// indices differ when both are enabled.
module fill_entry_bank
    import fill_pool_pkg::*;
#(
    parameter int N      = 10,
    parameter int LINE_W = 34,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               alloc_en,
    input  logic [1:0][IDX_W-1:0]    alloc_idx,
    input  logic [1:0][LINE_W-1:0]   alloc_line,
    input  logic [1:0][2:0]          alloc_kind,
    input  logic                     fill_valid,
    input  logic [IDX_W-1:0]         fill_idx,
    input  logic                     drain_en,
    input  logic [IDX_W-1:0]         drain_idx,
    output logic [N-1:0][1:0]        state_vec,
    output logic [N-1:0][LINE_W-1:0] line_vec,
    output logic [N-1:0][2:0]        kind_vec
);

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic hit0, hit1, fill_hit, drain_hit;

        assign hit0      = alloc_en[0] && (alloc_idx[0] == IDX_W'(i));
        assign hit1      = alloc_en[1] && (alloc_idx[1] == IDX_W'(i));
        assign fill_hit  = fill_valid && (fill_idx == IDX_W'(i)) && (state_vec[i] == ES_WAIT);
        assign drain_hit = drain_en && (drain_idx == IDX_W'(i)) && (state_vec[i] == ES_WC);

        // Entry life cycle: open on allocation, close on fill or drain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_vec[i] <= ES_FREE;
                line_vec[i]  <= '0;
                kind_vec[i]  <= '0;
            end else if (hit0) begin
                state_vec[i] <= kind_is_stream(alloc_kind[0]) ? ES_WC : ES_WAIT;
                line_vec[i]  <= alloc_line[0];
                kind_vec[i]  <= alloc_kind[0];
            end else if (hit1) begin
                state_vec[i] <= kind_is_stream(alloc_kind[1]) ? ES_WC : ES_WAIT;
                line_vec[i]  <= alloc_line[1];
                kind_vec[i]  <= alloc_kind[1];
            end else if (fill_hit || drain_hit) begin
                state_vec[i] <= ES_FREE;
            end
        end
    end

endmodule

// File: rtl/fill_evt_counter.sv
`timescale 1ns/1ps
// Saturating event counter taking up to two increments per cycle.
module fill_evt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   inc,
    output logic [W-1:0] count
);

    logic [W:0] sum;

    // Add both increments with one carry bit for saturation.
    always_comb begin
        sum = {1'b0, count} + (W + 1)'(inc[0]) + (W + 1)'(inc[1]);
    end

    // Hold at all ones once the carry appears.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (sum[W]) count <= '1;
        else             count <= sum[W-1:0];
    end

endmodule

// File: rtl/fill_track_pool.sv
`timescale 1ns/1ps
// Fill-entry pool for outstanding first-level misses.
// Two request ports, served in port order. Every valid request is a miss.
// Opens entries, issues line requests one cycle later, merges same-line
// misses, write-combines streaming stores, throttles hardware prefetch, and
// counts refusals. Assumes requesters hold a refused request.
module fill_track_pool
    import fill_pool_pkg::*;
#(
    parameter int ENTRIES  = 10,
    parameter int ADDR_W   = 40,
    parameter int LINE_OFF = 6,
    parameter int EVT_W    = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [1:0]                          req_valid,
    input  logic [1:0][2:0]                     req_kind,
    input  logic [1:0][ADDR_W-LINE_OFF-1:0]     req_line,
    output logic [1:0]                          req_ready,
    output logic [1:0]                          nl_req_valid,
    output logic [1:0][$clog2(ENTRIES)-1:0]     nl_req_idx,
    output logic [1:0][ADDR_W-LINE_OFF-1:0]     nl_req_line,
    output logic [1:0][2:0]                     nl_req_kind,
    input  logic                                fill_valid,
    input  logic [$clog2(ENTRIES)-1:0]          fill_idx,
    output logic                                wc_drain_valid,
    output logic [$clog2(ENTRIES)-1:0]          wc_drain_idx,
    output logic [ADDR_W-LINE_OFF-1:0]          wc_drain_line,
    input  logic                                wc_drain_ready,
    input  logic [$clog2(ENTRIES+1)-1:0]        cfg_hwpf_limit,
    output logic [$clog2(ENTRIES+1)-1:0]        busy_count,
    output logic [EVT_W-1:0]                    full_events
);

    localparam int LINE_W = ADDR_W - LINE_OFF;
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int CNT_W  = $clog2(ENTRIES + 1);

    logic [ENTRIES-1:0][1:0]        state_vec;
    logic [ENTRIES-1:0][LINE_W-1:0] line_vec;
    logic [ENTRIES-1:0][2:0]        kind_vec;
    logic [ENTRIES-1:0]             free_vec;
    logic                           first_ok, second_ok;
    logic [IDX_W-1:0]               first_idx, second_idx;
    logic                           drain_fire;
    logic [1:0]                     hit;
    logic [1:0][IDX_W-1:0]          hit_idx;
    logic [1:0]                     stream, merge, suppress, need, alloc, stall;
    logic [1:0][IDX_W-1:0]          alloc_idx;
    logic                           same_line1, free1_ok;
    logic [IDX_W-1:0]               free1_idx;
    logic [CNT_W:0]                 occ0, occ1;
    logic [1:0]                     nl_v_q;
    logic [1:0][IDX_W-1:0]          nl_idx_q;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_free
        assign free_vec[i] = (state_vec[i] == ES_FREE);
    end

    // Occupancy: number of entries not free.
    always_comb begin
        busy_count = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!free_vec[i]) busy_count = busy_count + CNT_W'(1);
        end
    end

    // Offer the lowest-index write-combining entry to the next-level queue.
    always_comb begin
        wc_drain_valid = 1'b0;
        wc_drain_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (state_vec[i] == ES_WC) begin
                wc_drain_valid = 1'b1;
                wc_drain_idx   = IDX_W'(i);
            end
        end
    end
    assign wc_drain_line = line_vec[wc_drain_idx];
    assign drain_fire    = wc_drain_valid && wc_drain_ready;

    fill_free_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .free_vec   (free_vec),
        .first_ok   (first_ok),
        .first_idx  (first_idx),
        .second_ok  (second_ok),
        .second_idx (second_idx)
    );

    // One line comparator bank per port; streaming stores look for WC entries.
    for (genvar p = 0; p < 2; p++) begin : g_port
        assign stream[p] = kind_is_stream(req_kind[p]);

        fill_line_match #(.N(ENTRIES), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_match (
            .state_vec  (state_vec),
            .line_vec   (line_vec),
            .line       (req_line[p]),
            .want_state (stream[p] ? ES_WC : ES_WAIT),
            .mask_en    (drain_fire),
            .mask_idx   (wc_drain_idx),
            .hit        (hit[p]),
            .hit_idx    (hit_idx[p])
        );
    end

    // Port 0 decision: merge, suppress, allocate or stall.
    always_comb begin
        occ0        = {1'b0, busy_count};
        merge[0]    = req_valid[0] && kind_can_merge(req_kind[0]) && hit[0];
        suppress[0] = req_valid[0] && (req_kind[0] == RK_HWPF) && !merge[0] &&
                      ((occ0 > {1'b0, cfg_hwpf_limit}) || !first_ok);
        need[0]     = req_valid[0] && !merge[0] && !suppress[0];
        alloc[0]    = need[0] && first_ok;
        stall[0]    = need[0] && !first_ok;
        alloc_idx[0] = first_idx;
    end

    // Port 1 decision, seeing port 0's allocation of this cycle.
    always_comb begin
        same_line1  = alloc[0] && (req_line[1] == req_line[0]) && (stream[0] == stream[1]);
        free1_ok    = alloc[0] ? second_ok : first_ok;
        free1_idx   = alloc[0] ? second_idx : first_idx;
        occ1        = {1'b0, busy_count} + (CNT_W + 1)'(alloc[0]);
        merge[1]    = req_valid[1] && kind_can_merge(req_kind[1]) && (hit[1] || same_line1);
        suppress[1] = req_valid[1] && (req_kind[1] == RK_HWPF) && !merge[1] &&
                      ((occ1 > {1'b0, cfg_hwpf_limit}) || !free1_ok);
        need[1]     = req_valid[1] && !merge[1] && !suppress[1];
        alloc[1]    = need[1] && free1_ok;
        stall[1]    = need[1] && !free1_ok;
        alloc_idx[1] = free1_idx;
    end

    assign req_ready = ~stall;

    fill_entry_bank #(.N(ENTRIES), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc),
        .alloc_idx  (alloc_idx),
        .alloc_line (req_line),
        .alloc_kind (req_kind),
        .fill_valid (fill_valid),
        .fill_idx   (fill_idx),
        .drain_en   (drain_fire),
        .drain_idx  (wc_drain_idx),
        .state_vec  (state_vec),
        .line_vec   (line_vec),
        .kind_vec   (kind_vec)
    );

    fill_evt_counter #(.W(EVT_W)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (stall),
        .count (full_events)
    );

    // Register newly opened fill-waiting entries as next-level line requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nl_v_q   <= '0;
            nl_idx_q <= '0;
        end else begin
            nl_v_q[0]   <= alloc[0] && !stream[0];
            nl_v_q[1]   <= alloc[1] && !stream[1];
            nl_idx_q[0] <= alloc_idx[0];
            nl_idx_q[1] <= alloc_idx[1];
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_nl
        assign nl_req_valid[p] = nl_v_q[p];
        assign nl_req_idx[p]   = nl_idx_q[p];
        assign nl_req_line[p]  = line_vec[nl_idx_q[p]];
        assign nl_req_kind[p]  = kind_vec[nl_idx_q[p]];
    end

endmodule

// File: rtl/fill_track_pool_chk.sv
`timescale 1ns/1ps
// Protocol checker for the fill-entry pool, bound to every instance.
module fill_track_pool_chk #(
    parameter int ENTRIES = 10,
    parameter int EVT_W   = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [1:0]                       req_ready,
    input logic [$clog2(ENTRIES+1)-1:0]     busy_count,
    input logic [EVT_W-1:0]                 full_events,
    input logic [1:0]                       nl_req_valid,
    input logic [1:0][$clog2(ENTRIES)-1:0]  nl_req_idx,
    input logic                             wc_drain_valid,
    input logic                             wc_drain_ready,
    input logic [$clog2(ENTRIES)-1:0]       wc_drain_idx
);
    localparam int CNT_W = $clog2(ENTRIES + 1);

    // R3: occupancy never exceeds the pool size.
    p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_count <= CNT_W'(ENTRIES));

    // R5: port 0 is refused only with every entry occupied.
    p_stall0_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready[0] |-> busy_count == CNT_W'(ENTRIES));

    // R5: port 1 is refused only when at most one entry was free.
    p_stall1_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready[1] |-> busy_count >= CNT_W'(ENTRIES - 1));

    // R6: the refusal counter never falls and rises by at most two.
    p_evt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (full_events >= $past(full_events)) &&
                 (({1'b0, full_events} - {1'b0, $past(full_events)}) <= (EVT_W + 1)'(2)));

    // R7: two line requests in one cycle name different entries.
    p_issue_distinct_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&nl_req_valid) |-> nl_req_idx[0] != nl_req_idx[1]);

    // R9: a drained entry is not offered again on the next cycle.
    p_drain_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_drain_valid && wc_drain_ready) |=>
            (!wc_drain_valid || wc_drain_idx != $past(wc_drain_idx)));

endmodule

bind fill_track_pool fill_track_pool_chk #(.ENTRIES(ENTRIES), .EVT_W(EVT_W)) u_chk (.*);

// File: tb/test_fill_track_pool.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared every cycle against a behavioural model of the requirements.
module test_fill_track_pool;
    localparam int ENTRIES = 10;
    localparam int LINE_W  = 34;
    localparam int IDX_W   = 4;
    localparam int CNT_W   = 4;
    localparam int EVT_W   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]              req_valid = '0;
    logic [1:0][2:0]         req_kind = '0;
    logic [1:0][LINE_W-1:0]  req_line = '0;
    logic [1:0]              req_ready;
    logic [1:0]              nl_req_valid;
    logic [1:0][IDX_W-1:0]   nl_req_idx;
    logic [1:0][LINE_W-1:0]  nl_req_line;
    logic [1:0][2:0]         nl_req_kind;
    logic                    fill_valid = 1'b0;
    logic [IDX_W-1:0]        fill_idx = '0;
    logic                    wc_drain_valid;
    logic [IDX_W-1:0]        wc_drain_idx;
    logic [LINE_W-1:0]       wc_drain_line;
    logic                    wc_drain_ready = 1'b0;
    logic [CNT_W-1:0]        cfg_hwpf_limit = 4'd10;
    logic [CNT_W-1:0]        busy_count;
    logic [EVT_W-1:0]        full_events;

    always #2.5 clk = ~clk;

    fill_track_pool i_fill_track_pool (.*);

    int n_tests = 0;
    int n_fail  = 0;

    int               m_state [ENTRIES];
    logic [LINE_W-1:0] m_line [ENTRIES];
    logic [2:0]       m_kind  [ENTRIES];
    logic [EVT_W-1:0] m_evt;
    bit               e_nlv [2];
    int               e_nli [2];

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < ENTRIES; i++) begin
            m_state[i] = 0;
            m_line[i]  = '0;
            m_kind[i]  = '0;
        end
        m_evt = '0;
        e_nlv = '{0, 0};
        e_nli = '{0, 0};
    endtask

    // Check all outputs against the model, advance the model, and move to
    // the next falling edge. Inputs must be set before calling.
    task automatic step();
        int busy, dr, fr, stalls;
        int a [2];
        bit rdy [2];
        bit hit, dfire, nt;
        #1;
        busy = 0;
        dr = -1;
        for (int i = 0; i < ENTRIES; i++) begin
            if (m_state[i] != 0) busy++;
            if (m_state[i] == 2 && dr < 0) dr = i;
        end
        dfire = (dr >= 0) && wc_drain_ready;
        a = '{-1, -1};
        stalls = 0;
        for (int p = 0; p < 2; p++) begin
            rdy[p] = 1;
            if (!req_valid[p]) continue;
            nt = (req_kind[p] == 3'd7);
            hit = 0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (m_line[i] == req_line[p] &&
                    (nt ? (m_state[i] == 2 && !(dfire && i == dr)) : (m_state[i] == 1)))
                    hit = 1;
            end
            if (p == 1 && a[0] >= 0 && req_line[0] == req_line[1] && ((req_kind[0] == 3'd7) == nt))
                hit = 1;
            if (hit && req_kind[p] != 3'd1) continue;
            fr = -1;
            for (int i = 0; i < ENTRIES; i++)
                if (m_state[i] == 0 && i != a[0] && fr < 0) fr = i;
            if (req_kind[p] == 3'd6 &&
                ((busy + (a[0] >= 0 ? 1 : 0)) > int'(cfg_hwpf_limit) || fr < 0)) continue;
            if (fr < 0) begin
                rdy[p] = 0;
                stalls++;
                continue;
            end
            a[p] = fr;
        end
        for (int p = 0; p < 2; p++) begin
            chk("R5", $sformatf("req_ready[%0d]", p), req_ready[p], rdy[p]);
            chk("R2", $sformatf("nl_req_valid[%0d]", p), nl_req_valid[p], e_nlv[p]);
            if (e_nlv[p]) begin
                chk("R2", "nl_req_idx", nl_req_idx[p], e_nli[p]);
                chk("R2", "nl_req_line", nl_req_line[p], m_line[e_nli[p]]);
                chk("R2", "nl_req_kind", nl_req_kind[p], m_kind[e_nli[p]]);
            end
        end
        chk("R3", "busy_count", busy_count, busy);
        chk("R6", "full_events", full_events, m_evt);
        chk("R9", "wc_drain_valid", wc_drain_valid, dr >= 0);
        if (dr >= 0) begin
            chk("R9", "wc_drain_idx", wc_drain_idx, dr);
            chk("R9", "wc_drain_line", wc_drain_line, m_line[dr]);
        end
        if (fill_valid && fill_idx < ENTRIES && m_state[fill_idx] == 1) m_state[fill_idx] = 0;
        if (dfire) m_state[dr] = 0;
        for (int p = 0; p < 2; p++) begin
            e_nlv[p] = 0;
            if (a[p] >= 0) begin
                m_state[a[p]] = (req_kind[p] == 3'd7) ? 2 : 1;
                m_line[a[p]]  = req_line[p];
                m_kind[a[p]]  = req_kind[p];
                e_nlv[p] = (req_kind[p] != 3'd7);
                e_nli[p] = a[p];
            end
        end
        if (int'(m_evt) + stalls > 16'hFFFF) m_evt = '1;
        else m_evt = m_evt + EVT_W'(stalls);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(bit v0, logic [2:0] k0, logic [LINE_W-1:0] l0,
                         bit v1, logic [2:0] k1, logic [LINE_W-1:0] l1);
        req_valid[0] = v0; req_kind[0] = k0; req_line[0] = l0;
        req_valid[1] = v1; req_kind[1] = k1; req_line[1] = l1;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0);
        fill_valid = 0;
        wc_drain_ready = 0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    // Open all ten entries with cacheable loads to lines base..base+9.
    task automatic fill_pool(logic [LINE_W-1:0] base);
        for (int j = 0; j < 5; j++) begin
            drive(1, 3'd0, base + LINE_W'(2 * j), 1, 3'd0, base + LINE_W'(2 * j + 1));
            step();
        end
        idle();
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R1: reset state.
        chk("R1", "busy_count", busy_count, 0);
        chk("R1", "full_events", full_events, 0);
        chk("R1", "nl_req_valid", nl_req_valid, 0);
        chk("R1", "wc_drain_valid", wc_drain_valid, 0);
        step();

        // R2: single load takes index 0 and issues next cycle.
        drive(1, 3'd0, 34'h100, 0, 0, 0); step(); idle();
        chk("R2", "first nl valid", nl_req_valid, 2'b01);
        chk("R2", "first nl idx", nl_req_idx[0], 0);
        chk("R2", "first nl line", nl_req_line[0], 34'h100);
        // R4, R7: two prefetches together; port 0 gets the lower index.
        drive(1, 3'd4, 34'h200, 1, 3'd5, 34'h300); step(); idle();
        chk("R7", "port0 idx", nl_req_idx[0], 1);
        chk("R7", "port1 idx", nl_req_idx[1], 2);
        chk("R4", "busy after prefetch", busy_count, 3);
        // R3: fill to a free index is ignored; fill to index 1 frees it.
        fill_valid = 1; fill_idx = 4'd9; step(); idle();
        chk("R3", "stray fill ignored", busy_count, 3);
        fill_valid = 1; fill_idx = 4'd1; step(); idle();
        chk("R3", "fill frees", busy_count, 2);
        drive(1, 3'd2, 34'h400, 0, 0, 0); step(); idle();
        chk("R2", "reuse lowest idx", nl_req_idx[0], 1);
        // R8: store to waiting line merges; uncacheable load does not.
        drive(1, 3'd2, 34'h100, 0, 0, 0); step(); idle();
        chk("R8", "merge busy", busy_count, 3);
        chk("R8", "merge no nl", nl_req_valid, 0);
        drive(1, 3'd1, 34'h100, 0, 0, 0); step(); idle();
        chk("R8", "uc no merge busy", busy_count, 4);
        // Fill the pool, then hold two requests against it.
        drive(1, 3'd0, 34'h500, 1, 3'd0, 34'h501); step();
        drive(1, 3'd0, 34'h502, 1, 3'd0, 34'h503); step();
        drive(1, 3'd0, 34'h504, 1, 3'd0, 34'h505); step();
        chk("R5", "pool full", busy_count, 10);
        drive(1, 3'd3, 34'h900, 1, 3'd2, 34'hA00);
        #1 chk("R5", "both refused", req_ready, 2'b00);
        step(); step(); step();
        chk("R6", "two per cycle", full_events, 6);
        fill_valid = 1; fill_idx = 4'd4; step(); fill_valid = 0;
        step();
        chk("R4", "held prefetch issued", nl_req_valid, 2'b01);
        chk("R4", "held prefetch idx", nl_req_idx[0], 4);
        chk("R4", "held prefetch line", nl_req_line[0], 34'h900);
        drive(0, 0, 0, 1, 3'd2, 34'hA00);
        fill_valid = 1; fill_idx = 4'd5; step(); fill_valid = 0;
        step(); idle();
        chk("R5", "held store issued", nl_req_idx[1], 5);

        // R9: streaming store, merge, then drain.
        do_reset();
        drive(1, 3'd7, 34'hB00, 0, 0, 0); step();
        chk("R9", "wc offered", wc_drain_valid, 1);
        chk("R9", "wc line", wc_drain_line, 34'hB00);
        chk("R9", "wc no line req", nl_req_valid, 0);
        step(); idle();
        chk("R9", "wc merge", busy_count, 1);
        wc_drain_ready = 1; step(); idle();
        chk("R9", "wc released", busy_count, 0);
        chk("R9", "wc gone", wc_drain_valid, 0);

        // R10: hardware prefetch throttling.
        do_reset();
        cfg_hwpf_limit = 4'd1;
        drive(1, 3'd0, 34'h10, 0, 0, 0); step();
        drive(1, 3'd6, 34'h20, 0, 0, 0); step();
        chk("R10", "hwpf under limit", busy_count, 2);
        drive(1, 3'd6, 34'h30, 0, 0, 0); step(); idle();
        chk("R10", "hwpf suppressed", busy_count, 2);
        chk("R10", "hwpf no nl", nl_req_valid, 0);
        chk("R10", "hwpf no count", full_events, 0);
        cfg_hwpf_limit = 4'd10;

        // R6: saturation after long refusal.
        do_reset();
        fill_pool(34'h1000);
        drive(1, 3'd0, 34'h7000, 1, 3'd3, 34'h7001);
        for (int j = 0; j < 33000; j++) step();
        idle();
        chk("R6", "saturated", full_events, 16'hFFFF);

        // Random traffic over a few lines.
        do_reset();
        for (int j = 0; j < 20000; j++) begin
            if (j % 1000 == 0) cfg_hwpf_limit = CNT_W'($urandom_range(0, 10));
            for (int p = 0; p < 2; p++) begin
                req_valid[p] = ($urandom_range(0, 9) < 7);
                req_kind[p]  = 3'($urandom_range(0, 7));
                req_line[p]  = LINE_W'($urandom_range(0, 7));
            end
            fill_valid     = ($urandom_range(0, 9) < 4);
            fill_idx       = IDX_W'($urandom_range(0, 11));
            wc_drain_ready = $urandom_range(0, 1);
            step();
        end
        idle();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule